// File: doc/BRIEF.md
# Six-digit hexadecimal push-button counter

A 24-bit counter that advances by a fixed step each time a button or switch is pressed, and shows its value as six hexadecimal digits on six separate seven-segment displays. The count lives in a register of positive-edge flip-flops. Its next value comes from an adder whose second operand is the constant step. The step defaults to one and the sum wraps modulo 2^24.

The raw button level is brought into the clock domain by a two-stage synchronizer. An edge detector then turns each press into a single one-cycle count request, however long the button is held. Each display digit has its own decoder, so all 42 segment lines update in parallel from the register value, with no multiplexing. A synchronous active-high reset clears the count. It also arms the edge detector so that a button still held when reset ends does not count.

Top module: `hexcount6`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0, so every digit shows the glyph 0 (7'h40 on its segment bus).
- R2: Each low-to-high transition of `btn` adds exactly `STEP` to the count once, whether the button is held for one cycle or many.
- R3: The sum wraps modulo 2^24 with no carry kept. With `STEP` = 24'hFFFFFF, two presses from zero give 24'hFFFFFE.
- R4: Digit output `seg<i>` shows count bits [4i+3:4i]: `seg0` shows bits 3:0 and `seg5` shows bits 23:20.
- R5: Segment lines are active-low, with segment a at bit 0 through segment g at bit 6. The values 0–F map to 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E (hex). b and d are lowercase glyphs.
- R6: If `btn` first reads high at clock edge k, the display keeps its old value after edges k and k+1 and shows the new value after edge k+2.
- R7: A reset at the same edge where a count request would take effect wins: the count is 0 after that edge.
- R8: A button level that is still high when reset is released is not counted. Counting resumes only after a release and a new press.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | System clock, rising edge active |
| rst  | input  | 1 | Synchronous reset, active high |
| btn  | input  | 1 | Asynchronous count-request level from a button or switch |
| seg0 | output | 7 | Digit 0 segments (bits 3:0 of the count), active low, a..g at 0..6 |
| seg1 | output | 7 | Digit 1 segments (bits 7:4) |
| seg2 | output | 7 | Digit 2 segments (bits 11:8) |
| seg3 | output | 7 | Digit 3 segments (bits 15:12) |
| seg4 | output | 7 | Digit 4 segments (bits 19:16) |
| seg5 | output | 7 | Digit 5 segments (bits 23:20) |

## Verification
Reset and a count request can land on the same clock edge. The bench provokes this by raising `btn` two edges before it asserts reset for exactly the edge at which the increment would take effect. It then keeps the button held through and after reset release. All six digits must read zero right after that edge, and they must still read zero several cycles later, until a fresh press advances them by one step. A second instance, built with an all-ones step, checks that the adder wraps as modulo arithmetic.

// File: rtl/hexcount6.sv
module hexcount6 #(
  parameter logic [23:0] STEP = 24'd1,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       btn,
  output logic [6:0] seg0,
  output logic [6:0] seg1,
  output logic [6:0] seg2,
  output logic [6:0] seg3,
  output logic [6:0] seg4,
  output logic [6:0] seg5
);
  localparam int ND = 6;
  localparam int W  = 4 * ND;

  logic [SYNC-1:0] sq;
  logic            prev;
  logic            pulse;
  logic [W-1:0]    count;
  logic [6:0]      segs [ND];

  function automatic logic [6:0] hex7(input logic [3:0] v);
    logic [6:0] on;
    case (v)
      4'h0: on = 7'h3F;
      4'h1: on = 7'h06;
      4'h2: on = 7'h5B;
      4'h3: on = 7'h4F;
      4'h4: on = 7'h66;
      4'h5: on = 7'h6D;
      4'h6: on = 7'h7D;
      4'h7: on = 7'h07;
      4'h8: on = 7'h7F;
      4'h9: on = 7'h6F;
      4'hA: on = 7'h77;
      4'hB: on = 7'h7C;
      4'hC: on = 7'h39;
      4'hD: on = 7'h5E;
      4'hE: on = 7'h79;
      default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sq   <= '1;
      prev <= 1'b1;
    end else begin
      sq   <= {sq[SYNC-2:0], btn};
      prev <= sq[SYNC-1];
    end
  end

  assign pulse = sq[SYNC-1] & ~prev;

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (pulse) count <= count + STEP;
  end

  for (genvar g = 0; g < ND; g++) begin : g_dig
    assign segs[g] = hex7(count[4*g +: 4]);
  end

  assign seg0 = segs[0];
  assign seg1 = segs[1];
  assign seg2 = segs[2];
  assign seg3 = segs[3];
  assign seg4 = segs[4];
  assign seg5 = segs[5];
endmodule

module hexcount6_chk #(
  parameter logic [23:0] STEP = 24'd1
) (
  input logic        clk,
  input logic        rst,
  input logic        pulse,
  input logic [23:0] count,
  input logic [6:0]  seg0
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> count == 24'd0); // R1
  AST_STEP_ADDS: assert property (@(posedge clk) disable iff (rst)
    pulse |=> count == $past(count) + STEP); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pulse |=> $stable(count)); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R2
  AST_SEG_STABLE: assert property (@(posedge clk) disable iff (rst)
    $stable(count) |-> $stable(seg0)); // R4
endmodule

bind hexcount6 hexcount6_chk #(.STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .pulse(pulse), .count(count), .seg0(seg0));

// File: tb/sim_hexcount6.sv
module sim_hexcount6;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic [6:0] a0, a1, a2, a3, a4, a5;
  logic [6:0] b0, b1, b2, b3, b4, b5;
  logic [23:0] m0 = 24'd0;
  logic [23:0] m1 = 24'd0;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  hexcount6 u0 (.clk(clk), .rst(rst), .btn(btn),
    .seg0(a0), .seg1(a1), .seg2(a2), .seg3(a3), .seg4(a4), .seg5(a5));
  hexcount6 #(.STEP(24'hFFFFFF)) u1 (.clk(clk), .rst(rst), .btn(btn),
    .seg0(b0), .seg1(b1), .seg2(b2), .seg3(b3), .seg4(b4), .seg5(b5));

  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                           7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[v];
  endfunction

  function automatic logic [41:0] show(input logic [23:0] v);
    logic [41:0] r;
    for (int i = 0; i < 6; i++) r[7*i +: 7] = glyph(v[4*i +: 4]);
    return r;
  endfunction

  task automatic check(input string req, input logic [23:0] exp0, input logic [23:0] exp1);
    logic [41:0] g0, g1;
    g0 = {a5, a4, a3, a2, a1, a0};
    g1 = {b5, b4, b3, b2, b1, b0};
    checks += 2;
    if (g0 !== show(exp0)) begin
      errors++;
      $display("FAIL %s u0: actual %h expected %h (count %h)", req, g0, show(exp0), exp0);
    end
    if (g1 !== show(exp1)) begin
      errors++;
      $display("FAIL %s u1: actual %h expected %h (count %h)", req, g1, show(exp1), exp1);
    end
  endtask

  task automatic press(input int hold, input int gap, input string req);
    @(negedge clk) btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (gap) @(negedge clk);
    m0 = m0 + 24'd1;
    m1 = m1 + 24'hFFFFFF;
    check(req, m0, m1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", 24'd0, 24'd0);

    press(1, 3, "R2");
    press(7, 2, "R2");
    press(2, 2, "R3");

    @(negedge clk) btn = 1'b1;
    @(negedge clk) check("R6", m0, m1);
    @(negedge clk) check("R6", m0, m1);
    m0 = m0 + 24'd1; m1 = m1 + 24'hFFFFFF;
    @(negedge clk) check("R6", m0, m1);
    btn = 1'b0;
    repeat (3) @(negedge clk);

    for (int n = 0; n < 60; n++) begin
      int h, g;
      h = 1 + ($urandom % 6);
      g = 2 + ($urandom % 5);
      press(h, g, "R4 R5");
    end

    @(negedge clk) btn = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    m0 = 24'd0; m1 = 24'd0;
    check("R7", m0, m1);
    repeat (5) @(negedge clk);
    check("R8", m0, m1);
    btn = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", m0, m1);
    press(3, 3, "R8");

    for (int v = 0; v < 16; v++) begin
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      m0 = 24'd0; m1 = 24'd0;
      for (int k = 0; k < v; k++) press(1, 2, "R5");
      check("R5", m0, m1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule